// File: doc/BRIEF.md
# Privilege-Gated Counter CSR Unit

This block is the control/status register slice of a 64-bit hart that holds the machine identification and status words and three free-running 64-bit counters. The counters are cycles, wall-clock ticks and retired instructions. A single index selects one entry. A read strobe returns its value in the same cycle. A write strobe updates a stored entry at the next rising clock edge.

Counter reads are filtered by the privilege level currently in force. Machine mode sees everything. Supervisor mode consults the machine-level enable mask only, and user mode consults the supervisor-level mask only. A denied read quietly yields zero. The 29 performance-counter slots have no counters of their own: each returns the cycle count. The whole counter range is read-only.

Index map (6-bit default index): 0 cycle, 1 time, 2 instret, 3..31 performance counters, 32 ISA word, 33 vendor ID, 34 architecture ID, 35 implementation ID, 36 hart ID, 37 status, 38 machine counter-enable, 39 supervisor counter-enable. Indices 40 and up are unimplemented. Privilege codes: 2'b11 machine, 2'b01 supervisor, 2'b00 and 2'b10 user.

Top module: `ctr_csr_unit`

## Requirements
- R1: After reset, index 32 reads 64'h8000_0000_0014_112D, index 37 reads 64'h0000_000A_0000_2000, indices 38 and 39 read 64'h7, and indices 33, 34, 35 and all counters read 0.
- R2: The cycle counter advances by one every clock after reset; the time counter advances on each clock with tick high; the instret counter advances on each clock with retire high.
- R3: With privilege 2'b11, a read of any counter index 0..31 returns the counter value regardless of both enable masks.
- R4: With privilege 2'b01, a read of counter index n returns its value only when bit n of the machine counter-enable register (index 38) is 1.
- R5: With privilege 2'b00 or 2'b10, a read of counter index n returns its value only when bit n of the supervisor counter-enable register (index 39) is 1; the machine mask plays no part.
- R6: A counter read that is denied returns 0 and does not raise the illegal flag.
- R7: Indices 3 through 31 return the cycle count when their read is permitted.
- R8: A write to any index 0..31 changes no counter value.
- R9: A read of index 36 returns the hart_id input; writes there have no effect.
- R10: A read or write of an index of 40 or above raises illegal in that cycle; a read there returns all ones, and a write there changes no stored register.
- R11: A write to indices 32..35, 37, 38 or 39 stores wdata, which is visible to reads from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| priv | input | 2 | Current privilege level |
| retire | input | 1 | One instruction retired this cycle |
| tick | input | 1 | Wall-clock tick this cycle |
| hart_id | input | 64 | Identifier of this hart |
| idx | input | 6 | Register index |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, zero when rd_en is low |
| illegal | output | 1 | Unimplemented index accessed |

## Verification
The bench goes after the mask cross-over: a supervisor read with only the supervisor bit set, and a user read with only the machine bit set. A design that consulted the wrong mask, or chained both, would return a count where zero is due or the reverse. It also reads performance slots, which a design that did not alias them would answer with zero. It writes into the counter range, where a design that stored the write would show a jumped count. It touches the first unimplemented index, 40, where an off-by-one decode would hand back a value without the flag.

// File: rtl/ctrgate_pkg.sv
package ctrgate_pkg;
   typedef enum logic [1:0] {
      PRIV_USR = 2'b00,
      PRIV_SUP = 2'b01,
      PRIV_RSV = 2'b10,
      PRIV_MCH = 2'b11
   } priv_e;

   localparam int NUM_CTR    = 32;
   localparam int NUM_STORE  = 8;
   localparam int IX_CYCLE   = 0;
   localparam int IX_TIME    = 1;
   localparam int IX_INSTRET = 2;
   localparam int IX_BASE    = 32;
   localparam int SLOT_ISA   = 0;
   localparam int SLOT_HART  = 4;
   localparam int SLOT_STAT  = 5;
   localparam int SLOT_MEN   = 6;
   localparam int SLOT_SEN   = 7;

   function automatic logic [63:0] slot_reset(input int slot);
      logic [63:0] v;
      v = '0;
      case (slot)
         SLOT_ISA:  v = (64'd2 << 62) | 64'h14112D;
         SLOT_STAT: v = (64'd2 << 32) | (64'd2 << 34) | (64'd1 << 13);
         SLOT_MEN,
         SLOT_SEN:  v = 64'h7;
         default:   v = '0;
      endcase
      return v;
   endfunction
endpackage

// File: rtl/ctr_bank.sv
module ctr_bank #(
   parameter int CNT_W = 64
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   retire,
   input  logic                   tick,
   output logic [2:0][CNT_W-1:0]  cnt
);
   logic [2:0] inc;
   assign inc = {retire, tick, 1'b1};

   for (genvar g = 0; g < 3; g++) begin : g_ctr
      logic [CNT_W-1:0] q;
      always_ff @(posedge clk) begin
         if (rst)         q <= '0;
         else if (inc[g]) q <= q + 1'b1;
      end
      assign cnt[g] = q;
   end
endmodule

// File: rtl/ctr_perm.sv
module ctr_perm
   import ctrgate_pkg::*;
#(
   parameter int N = NUM_CTR,
   localparam int OFF_W = $clog2(N)
) (
   input  priv_e            priv,
   input  logic [N-1:0]     m_en,
   input  logic [N-1:0]     s_en,
   input  logic [OFF_W-1:0] off,
   output logic             allow
);
   always_comb begin
      case (priv)
         PRIV_MCH: allow = 1'b1;
         PRIV_SUP: allow = m_en[off];
         default:  allow = s_en[off];
      endcase
   end
endmodule

// File: rtl/csr_store.sv
module csr_store
   import ctrgate_pkg::*;
#(
   parameter int XLEN = 64,
   localparam int SLOT_W = $clog2(NUM_STORE)
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           wr,
   input  logic [SLOT_W-1:0]              slot,
   input  logic [XLEN-1:0]                wdata,
   output logic [NUM_STORE-1:0][XLEN-1:0] regs
);
   for (genvar s = 0; s < NUM_STORE; s++) begin : g_slot
      if (s == SLOT_HART) begin : g_none
         assign regs[s] = '0;
      end else begin : g_reg
         logic [XLEN-1:0] q;
         always_ff @(posedge clk) begin
            if (rst)                                q <= XLEN'(slot_reset(s));
            else if (wr && slot == SLOT_W'(s))      q <= wdata;
         end
         assign regs[s] = q;
      end
   end
endmodule

// File: rtl/ctr_csr_unit.sv
module ctr_csr_unit
   import ctrgate_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int CNT_W = 64,
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       priv,
   input  logic             retire,
   input  logic             tick,
   input  logic [XLEN-1:0]  hart_id,
   input  logic [IDX_W-1:0] idx,
   input  logic             rd_en,
   input  logic             wr_en,
   input  logic [XLEN-1:0]  wdata,
   output logic [XLEN-1:0]  rdata,
   output logic             illegal
);
   localparam int OFF_W  = $clog2(NUM_CTR);
   localparam int SLOT_W = $clog2(NUM_STORE);
   localparam logic [IDX_W-1:0] CTR_END   = IDX_W'(NUM_CTR);
   localparam logic [IDX_W-1:0] STORE_END = IDX_W'(IX_BASE + NUM_STORE);

   if (XLEN != 64) begin : g_bad_xlen
      $error("ctr_csr_unit: XLEN must be 64");
   end
   if (CNT_W < 1 || CNT_W > XLEN) begin : g_bad_cnt
      $error("ctr_csr_unit: CNT_W must lie in 1..XLEN");
   end
   if (IDX_W < 6) begin : g_bad_idx
      $error("ctr_csr_unit: IDX_W must be at least 6");
   end

   logic [2:0][CNT_W-1:0]          cnt_w;
   logic [NUM_STORE-1:0][XLEN-1:0] store_w;
   logic                           is_ctr, is_store, legal, allow;
   logic [OFF_W-1:0]               off;
   logic [SLOT_W-1:0]              slot;
   logic [CNT_W-1:0]               ctr_val;

   assign is_ctr   = idx < CTR_END;
   assign is_store = !is_ctr && idx < STORE_END;
   assign legal    = is_ctr || is_store;
   assign off      = idx[OFF_W-1:0];
   assign slot     = idx[SLOT_W-1:0];

   ctr_bank #(.CNT_W(CNT_W)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .retire (retire),
      .tick   (tick),
      .cnt    (cnt_w)
   );

   csr_store #(.XLEN(XLEN)) u_store (
      .clk   (clk),
      .rst   (rst),
      .wr    (wr_en && is_store),
      .slot  (slot),
      .wdata (wdata),
      .regs  (store_w)
   );

   ctr_perm #(.N(NUM_CTR)) u_perm (
      .priv  (priv_e'(priv)),
      .m_en  (store_w[SLOT_MEN][NUM_CTR-1:0]),
      .s_en  (store_w[SLOT_SEN][NUM_CTR-1:0]),
      .off   (off),
      .allow (allow)
   );

   always_comb begin
      case (off)
         OFF_W'(IX_TIME):    ctr_val = cnt_w[1];
         OFF_W'(IX_INSTRET): ctr_val = cnt_w[2];
         default:            ctr_val = cnt_w[0];
      endcase
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         if (!legal)                   rdata = '1;
         else if (is_ctr)              rdata = allow ? XLEN'(ctr_val) : '0;
         else if (slot == SLOT_W'(SLOT_HART)) rdata = hart_id;
         else                          rdata = store_w[slot];
      end
   end

   assign illegal = (rd_en || wr_en) && !legal;
endmodule

// File: rtl/ctr_csr_unit_chk.sv
module ctr_csr_unit_chk
   import ctrgate_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int CNT_W = 64,
   parameter int IDX_W = 6
) (
   input logic             clk,
   input logic             rst,
   input logic [1:0]       priv,
   input logic             tick,
   input logic [XLEN-1:0]  hart_id,
   input logic [IDX_W-1:0] idx,
   input logic             rd_en,
   input logic             wr_en,
   input logic [XLEN-1:0]  rdata,
   input logic             illegal,
   input logic [CNT_W-1:0] cyc_q,
   input logic [CNT_W-1:0] tim_q,
   input logic [31:0]      s_en
);
   assert_cycle_step_R2: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> cyc_q == $past(cyc_q) + 1'b1);

   assert_machine_sees_R3: assert property (@(posedge clk) disable iff (rst)
      (rd_en && priv == 2'b11 && idx == IDX_W'(IX_CYCLE)) |-> rdata == XLEN'(cyc_q));

   assert_user_denied_zero_R6: assert property (@(posedge clk) disable iff (rst)
      (rd_en && idx < IDX_W'(32) && priv[0] == 1'b0 && !s_en[idx[4:0]])
         |-> (rdata == '0 && !illegal));

   assert_time_write_drop_R8: assert property (@(posedge clk) disable iff (rst)
      (wr_en && idx == IDX_W'(IX_TIME) && !tick) |=> tim_q == $past(tim_q));

   assert_hart_passthru_R9: assert property (@(posedge clk) disable iff (rst)
      (rd_en && idx == IDX_W'(36)) |-> rdata == hart_id);

   assert_unimpl_flag_R10: assert property (@(posedge clk) disable iff (rst)
      (rd_en && idx >= IDX_W'(40)) |-> (illegal && rdata == '1));
endmodule

bind ctr_csr_unit ctr_csr_unit_chk #(.XLEN(XLEN), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .priv    (priv),
   .tick    (tick),
   .hart_id (hart_id),
   .idx     (idx),
   .rd_en   (rd_en),
   .wr_en   (wr_en),
   .rdata   (rdata),
   .illegal (illegal),
   .cyc_q   (cnt_w[0]),
   .tim_q   (cnt_w[1]),
   .s_en    (store_w[7][31:0])
);

// File: tb/ctr_csr_unit_test.sv
module ctr_csr_unit_test;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  priv = 2'b11;
   logic        retire = 1'b0, tick = 1'b0;
   logic [63:0] hart_id = 64'h0000_0000_0000_0005;
   logic [5:0]  idx = '0;
   logic        rd_en = 1'b0, wr_en = 1'b0;
   logic [63:0] wdata = '0;
   logic [63:0] rdata;
   logic        illegal;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   // bench model
   logic [63:0] m_cyc, m_tim, m_ir;
   logic [63:0] m_st [8];

   ctr_csr_unit uut (
      .clk(clk), .rst(rst), .priv(priv), .retire(retire), .tick(tick),
      .hart_id(hart_id), .idx(idx), .rd_en(rd_en), .wr_en(wr_en),
      .wdata(wdata), .rdata(rdata), .illegal(illegal)
   );

   always #(CLK_P/2) clk = ~clk;

   always @(posedge clk) begin
      if (rst) begin
         m_cyc <= 0; m_tim <= 0; m_ir <= 0;
         m_st[0] <= 64'h8000_0000_0014_112D;
         m_st[1] <= 0; m_st[2] <= 0; m_st[3] <= 0; m_st[4] <= 0;
         m_st[5] <= 64'h0000_000A_0000_2000;
         m_st[6] <= 64'h7; m_st[7] <= 64'h7;
      end else begin
         m_cyc <= m_cyc + 1;
         if (tick)   m_tim <= m_tim + 1;
         if (retire) m_ir  <= m_ir + 1;
         if (wr_en && idx >= 32 && idx < 40 && idx != 36) m_st[idx - 32] <= wdata;
      end
   end

   function automatic logic [63:0] exp_read(input logic [5:0] i, input logic [1:0] p);
      bit ok;
      if (i < 32) begin
         if (p == 2'b11)      ok = 1;
         else if (p == 2'b01) ok = m_st[6][i];
         else                 ok = m_st[7][i];
         if (!ok) return 0;
         if (i == 1) return m_tim;
         if (i == 2) return m_ir;
         return m_cyc;
      end
      if (i >= 40) return '1;
      if (i == 36) return hart_id;
      return m_st[i - 32];
   endfunction

   function automatic string tag_of(input logic [5:0] i, input logic [1:0] p);
      if (i >= 40) return "R10";
      if (i == 36) return "R9";
      if (i >= 32) return "R11";
      if (p == 2'b11) return (i >= 3) ? "R7" : "R3";
      if (p == 2'b01) return "R4";
      return "R5";
   endfunction

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // drive at negedge, sample 1 time unit later
   task automatic rd(input logic [5:0] i, input logic [1:0] p, input string tag);
      @(negedge clk);
      idx = i; priv = p; rd_en = 1; wr_en = 0;
      #1;
      check(tag, rdata, exp_read(i, p));
      check(tag, {63'd0, illegal}, {63'd0, i >= 40});
   endtask

   task automatic wr(input logic [5:0] i, input logic [63:0] d, input string tag);
      @(negedge clk);
      idx = i; wdata = d; wr_en = 1; rd_en = 0;
      #1;
      check(tag, {63'd0, illegal}, {63'd0, i >= 40});
      @(negedge clk);
      wr_en = 0;
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got hang expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [63:0] snap;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst = 0;
      #1;
      // R1: reset values, read immediately after reset at machine level
      check("R1", rdata, 64'h0);
      idx = 32; rd_en = 1; #1; check("R1", rdata, 64'h8000_0000_0014_112D);
      idx = 37; #1; check("R1", rdata, 64'h0000_000A_0000_2000);
      idx = 38; #1; check("R1", rdata, 64'h7);
      idx = 39; #1; check("R1", rdata, 64'h7);
      idx = 33; #1; check("R1", rdata, 64'h0);
      idx = 2;  #1; check("R1", rdata, 64'h0);
      rd_en = 0;

      // R2: counters advance on their own events
      @(negedge clk); tick = 1; retire = 0;
      @(negedge clk); tick = 0; retire = 1;
      @(negedge clk); retire = 1;
      @(negedge clk); retire = 0;
      rd(0, 2'b11, "R2"); rd(1, 2'b11, "R2"); rd(2, 2'b11, "R2");
      check("R2", m_tim, 64'd1);
      check("R2", m_ir, 64'd2);

      // R4: supervisor, default mask denies hpm 5, allows cycle
      rd(5, 2'b01, "R4"); check("R6", rdata, 64'h0);
      rd(0, 2'b01, "R4");
      // R5 vs R4 cross-over: machine mask only bit 9, supervisor mask only bit 10
      wr(38, 64'h200, "R11");
      wr(39, 64'h400, "R11");
      rd(9, 2'b00, "R5");  check("R5", rdata, 64'h0);
      rd(10, 2'b00, "R5"); check("R7", rdata, m_cyc);
      rd(10, 2'b01, "R4"); check("R4", rdata, 64'h0);
      rd(9, 2'b01, "R4");  check("R7", rdata, m_cyc);
      rd(10, 2'b10, "R5");
      // R3: machine ignores both masks
      rd(31, 2'b11, "R3"); check("R7", rdata, m_cyc);
      rd(1, 2'b11, "R3");

      // R8: writes into the counter range are dropped
      @(negedge clk); idx = 1; priv = 2'b11; rd_en = 1; #1; snap = rdata;
      wr(1, 64'hFFFF_0000, "R8");
      rd(1, 2'b11, "R8"); check("R8", rdata, snap);
      wr(0, 64'h1234, "R8"); rd(0, 2'b11, "R8");

      // R9: hart id passthrough, write ignored
      wr(36, 64'hDEAD, "R9");
      hart_id = 64'hABCD_0000_1111_2222;
      rd(36, 2'b00, "R9"); check("R9", rdata, 64'hABCD_0000_1111_2222);

      // R10: first unimplemented index and top index
      rd(40, 2'b11, "R10"); check("R10", rdata, '1);
      rd(63, 2'b00, "R10");
      wr(40, 64'h55, "R10");
      rd(39, 2'b11, "R10");

      // R11: stored write visible next cycle
      wr(33, 64'hCAFE_F00D, "R11"); rd(33, 2'b11, "R11");
      check("R11", rdata, 64'hCAFE_F00D);

      // random phase
      for (int n = 0; n < 3000; n++) begin
         int r;
         logic [5:0] i;
         logic [1:0] p;
         r = $urandom_range(0, 99);
         if (r < 55)      i = 6'($urandom_range(0, 31));
         else if (r < 90) i = 6'($urandom_range(32, 39));
         else             i = 6'($urandom_range(40, 63));
         p = 2'($urandom_range(0, 3));
         @(negedge clk);
         tick = 1'($urandom_range(0, 1));
         retire = 1'($urandom_range(0, 1));
         idx = i; priv = p;
         rd_en = 1'($urandom_range(0, 3) != 0);
         wr_en = 1'($urandom_range(0, 3) == 0);
         wdata = {$urandom, $urandom};
         #1;
         if (rd_en) check(tag_of(i, p), rdata, exp_read(i, p));
         else       check("R6", rdata, 64'h0);
         check("R10", {63'd0, illegal}, {63'd0, (rd_en || wr_en) && i >= 40});
      end
      @(negedge clk);
      rd_en = 0; wr_en = 0;
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule